// File: doc/BRIEF.md
# Eight-Line GPIO Port with Address-Masked Data and Line Interrupts

This block is an eight-line general-purpose I/O port on a simple single-cycle register bus. Each line is an input or an output on its own, set by a direction register. Data accesses use part of the address as a per-line bit mask. A masked write changes only the selected output lines, so software can update single lines without a read-modify-write sequence. A masked read returns zero for every line that is not selected.

Every input is resynchronised to the block clock. Each line can raise an interrupt in one of five ways: an active-high level, an active-low level, a rising edge, a falling edge, or either edge. Edge events are latched until software clears them by writing ones to a clear register. Level events follow the pin and are not latched. A per-line enable masks the status, and one combined interrupt output is the OR of the masked status bits.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads zero: direction, sense, both-edges, polarity, enable, raw status, masked status and the output value. `pin_oe`, `pin_out` and `irq` are low.
- R2: Registers are decoded only at word-aligned addresses (bits [1:0] zero):
  - 0x400 is direction, 0x404 is sense, 0x408 is both-edges, 0x40C is polarity and 0x410 is enable. Each of these reads back what was written.
  - 0x414 is raw status and 0x418 is masked status.
  - 0x41C is the clear register, which always reads zero.
  - Any other address at or above 0x400 reads zero.
  - A read at a misaligned address reads zero, and a write there changes nothing.
- R3: Data writes use addresses 0x000 to 0x3FC. Address bit n+2 selects line n. A write changes the output value only of lines that are selected and whose direction bit is 1. A write to a line that is an input leaves its output value unchanged, even if the line becomes an output later. `pin_oe` equals the direction register and `pin_out` equals the output value.
- R4: A data read returns, for each selected line, the output value if the line is an output and the synchronised pin if it is an input. Unselected lines read zero. A pin change is visible to a read after two clock edges.
- R5: With sense bit 1, raw status follows the synchronised pin without latching. Polarity 1 means active when the pin is high, polarity 0 means active when it is low. A change reaches raw status two clock edges after the pin changes.
- R6: With sense bit 0 and both-edges bit 0, polarity 1 latches rising edges and polarity 0 latches falling edges. The latched status appears three clock edges after the pin changes, not two.
- R7: With sense bit 0 and both-edges bit 1, both rising and falling edges are latched, whatever the polarity bit holds.
- R8: Masked status equals raw status AND enable. `irq` is high exactly when any masked status bit is set.
- R9: Writing a 1 to a bit of the clear register clears that line's latched edge status. Bits written as 0 leave their status unchanged. If a new edge is detected on the same clock edge as the clear, the status stays set.
- R10: Writes to raw status and masked status have no effect. A clear write does not remove level-mode status while the pin stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address while selected |
| pin_in | input | 8 | Asynchronous pad inputs |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, one per line |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted output value or direction bit shows on `pin_out` or `pin_oe` at the clock edge after the faulty write. The bench compares these pads against a model after every random masked write. A wrong synchroniser depth or a missing edge register shifts the time raw status rises: level status should appear after two clock edges and edge status after three. The bench samples at exactly those cycle boundaries. A status latch that mishandles a clear arriving with an edge shows up as a dropped raw bit and a low `irq` on the very next read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NLINES = 8;
    localparam int ADDR_W = 12;

    typedef logic [NLINES-1:0] lane_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t DATA_TOP = addr_t'(12'h3FC);
    localparam addr_t OFS_DIR  = addr_t'(12'h400);
    localparam addr_t OFS_SNS  = addr_t'(12'h404);
    localparam addr_t OFS_DUAL = addr_t'(12'h408);
    localparam addr_t OFS_POL  = addr_t'(12'h40C);
    localparam addr_t OFS_IEN  = addr_t'(12'h410);
    localparam addr_t OFS_RAW  = addr_t'(12'h414);
    localparam addr_t OFS_MSK  = addr_t'(12'h418);
    localparam addr_t OFS_CLR  = addr_t'(12'h41C);

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_DIR, SEL_SNS, SEL_DUAL,
        SEL_POL, SEL_IEN, SEL_RAW, SEL_MSK, SEL_CLR
    } reg_sel_e;

    typedef struct packed {
        lane_t dir;
        lane_t sense;
        lane_t dual;
        lane_t pol;
        lane_t ien;
    } cfg_t;

    function automatic reg_sel_e decode_addr(addr_t a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            if (a <= DATA_TOP) s = SEL_DATA;
            else begin
                case (a)
                    OFS_DIR:  s = SEL_DIR;
                    OFS_SNS:  s = SEL_SNS;
                    OFS_DUAL: s = SEL_DUAL;
                    OFS_POL:  s = SEL_POL;
                    OFS_IEN:  s = SEL_IEN;
                    OFS_RAW:  s = SEL_RAW;
                    OFS_MSK:  s = SEL_MSK;
                    OFS_CLR:  s = SEL_CLR;
                    default:  s = SEL_NONE;
                endcase
            end
        end
        return s;
    endfunction

    function automatic lane_t addr_mask(addr_t a);
        return a[NLINES+1:2];
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t async_i,
    output lane_t sync_o
);
    lane_t chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_event.sv
module gpio_event
    import gpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t sync_i,
    input  cfg_t  cfg_i,
    input  lane_t clr_i,
    output lane_t raw_o
);
    lane_t prev_q;
    lane_t latch_q;
    lane_t hit;
    lane_t latch_d;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sync_i;
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic rise, fall, chg;
        assign rise = sync_i[i] & ~prev_q[i];
        assign fall = ~sync_i[i] & prev_q[i];
        assign chg  = rise | fall;

        always_comb begin
            if (cfg_i.sense[i])     hit[i] = 1'b0;
            else if (cfg_i.dual[i]) hit[i] = chg;
            else if (cfg_i.pol[i])  hit[i] = rise;
            else                    hit[i] = fall;
            latch_d[i] = (latch_q[i] & ~clr_i[i]) | hit[i];
            raw_o[i] = cfg_i.sense[i] ? (sync_i[i] ~^ cfg_i.pol[i]) : latch_q[i];
        end

        // A latched bit only rises after the synchronised pin moved
        assert_edge_cause_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(latch_q[i]) |-> $past(sync_i[i] != prev_q[i]));

        // Clear without a concurrent transition empties the latch
        assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && (sync_i[i] == prev_q[i])) |=> !latch_q[i]);

        // A transition while a clear is written keeps the status
        assert_edge_wins_R9: assert property (@(posedge clk) disable iff (rst)
            (!cfg_i.sense[i] && cfg_i.dual[i] && (sync_i[i] != prev_q[i])) |=> latch_q[i]);

        // Level status is inactive whenever the pin is not at the active level
        assert_level_R5: assert property (@(posedge clk) disable iff (rst)
            (cfg_i.sense[i] && (sync_i[i] != cfg_i.pol[i])) |-> !raw_o[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= latch_d;
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_i,
    input  logic  wr_i,
    input  addr_t addr_i,
    input  lane_t wdata_i,
    output lane_t rdata_o,
    input  lane_t pin_sync_i,
    input  lane_t raw_i,
    input  lane_t masked_i,
    output cfg_t  cfg_o,
    output lane_t out_val_o,
    output lane_t clr_o
);
    cfg_t     cfg_q;
    lane_t    out_q;
    reg_sel_e sel_e;
    lane_t    amask;
    lane_t    wmask;
    logic     wr_go;

    always_comb begin
        sel_e = decode_addr(addr_i);
        amask = addr_mask(addr_i);
        wr_go = sel_i & wr_i;
        wmask = amask & cfg_q.dir;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            out_q <= '0;
        end else if (wr_go) begin
            case (sel_e)
                SEL_DATA: out_q       <= (out_q & ~wmask) | (wdata_i & wmask);
                SEL_DIR:  cfg_q.dir   <= wdata_i;
                SEL_SNS:  cfg_q.sense <= wdata_i;
                SEL_DUAL: cfg_q.dual  <= wdata_i;
                SEL_POL:  cfg_q.pol   <= wdata_i;
                SEL_IEN:  cfg_q.ien   <= wdata_i;
                default: ;
            endcase
        end
    end

    assign clr_o = (wr_go && sel_e == SEL_CLR) ? wdata_i : '0;

    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            case (sel_e)
                SEL_DATA: rdata_o = ((cfg_q.dir & out_q) | (~cfg_q.dir & pin_sync_i)) & amask;
                SEL_DIR:  rdata_o = cfg_q.dir;
                SEL_SNS:  rdata_o = cfg_q.sense;
                SEL_DUAL: rdata_o = cfg_q.dual;
                SEL_POL:  rdata_o = cfg_q.pol;
                SEL_IEN:  rdata_o = cfg_q.ien;
                SEL_RAW:  rdata_o = raw_i;
                SEL_MSK:  rdata_o = masked_i;
                default:  rdata_o = '0;
            endcase
        end
    end

    assign cfg_o     = cfg_q;
    assign out_val_o = out_q;

    // Lines outside the write mask or configured as inputs keep their value
    assert_masked_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_go && sel_e == SEL_DATA) |=>
            ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));

    // The clear register never returns data
    assert_clr_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !wr_i && sel_e == SEL_CLR) |-> (rdata_o == '0));

    // Output value only moves on a data write
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_go && sel_e == SEL_DATA) |=> $stable(out_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic              irq
);
    lane_t pin_sync;
    lane_t raw;
    lane_t masked;
    lane_t clr;
    lane_t out_val;
    cfg_t  cfg;

    gpio_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .async_i(pin_in), .sync_o(pin_sync)
    );

    gpio_event u_event (
        .clk(clk), .rst(rst), .sync_i(pin_sync), .cfg_i(cfg),
        .clr_i(clr), .raw_o(raw)
    );

    gpio_regfile u_regs (
        .clk(clk), .rst(rst), .sel_i(bus_sel), .wr_i(bus_write),
        .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .pin_sync_i(pin_sync), .raw_i(raw), .masked_i(masked),
        .cfg_o(cfg), .out_val_o(out_val), .clr_o(clr)
    );

    assign masked  = raw & cfg.ien;
    assign irq     = |masked;
    assign pin_out = out_val;
    assign pin_oe  = cfg.dir;

    // No enabled line means no request
    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg.ien == '0) |-> !irq);

    // A request always has an unmasked raw cause
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((raw & cfg.ien) != '0));

    // Output enables move only after a bus write
    assert_oe_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_write) |=> $stable(pin_oe));

    // Reset leaves all pads undriven
    assert_reset_pads_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [7:0] exp_write(logic [7:0] cur, logic [7:0] dir,
                                             logic [7:0] m, logic [7:0] wd);
        return (cur & ~(m & dir)) | (wd & m & dir);
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] dir, logic [7:0] outv,
                                            logic [7:0] pin, logic [7:0] m);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = m[i] & (dir[i] ? outv[i] : pin[i]);
        return r;
    endfunction

    function automatic logic [7:0] exp_level(logic [7:0] pin, logic [7:0] pol);
        return ~(pin ^ pol);
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [11:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got 00 expected 01");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] model_out;
        void'($urandom(32'h0000_5EED));
        tick(4);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk_reg("R1 dir", 12'h400, 8'h00);
        chk_reg("R1 sense", 12'h404, 8'h00);
        chk_reg("R1 dual", 12'h408, 8'h00);
        chk_reg("R1 pol", 12'h40C, 8'h00);
        chk_reg("R1 ien", 12'h410, 8'h00);
        chk_reg("R1 raw", 12'h414, 8'h00);
        chk_reg("R1 masked", 12'h418, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R2 register map readback
        wr(12'h404, 8'h5A); chk_reg("R2 sense", 12'h404, 8'h5A);
        wr(12'h408, 8'hC3); chk_reg("R2 dual", 12'h408, 8'hC3);
        wr(12'h40C, 8'h96); chk_reg("R2 pol", 12'h40C, 8'h96);
        wr(12'h410, 8'h00); chk_reg("R2 ien", 12'h410, 8'h00);
        wr(12'h41C, 8'hFF); chk_reg("R2 clear reads zero", 12'h41C, 8'h00);
        chk_reg("R2 unmapped", 12'h420, 8'h00);
        wr(12'h405, 8'hFF); chk_reg("R2 misaligned write ignored", 12'h404, 8'h5A);
        chk_reg("R2 misaligned read", 12'h401, 8'h00);
        wr(12'h404, 8'h00); wr(12'h408, 8'h00); wr(12'h40C, 8'h00);

        // R3 directed masked writes
        model_out = 8'h00;
        wr(12'h400, 8'h0F);
        chk("R3 pin_oe follows dir", pin_oe, 8'h0F);
        wr(12'h3FC, 8'hFF);
        model_out = exp_write(model_out, 8'h0F, 8'hFF, 8'hFF);
        chk("R3 only outputs written", pin_out, model_out);
        wr(12'h00C, 8'h00);
        model_out = exp_write(model_out, 8'h0F, 8'h03, 8'h00);
        chk("R3 mask lines 0-1", pin_out, model_out);
        wr(12'h400, 8'hFF);
        chk("R3 input write had no effect", pin_out, model_out);

        // R3 R4 random masked writes and reads
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d, m, wd, m2;
            d  = 8'($urandom);
            m  = 8'($urandom);
            wd = 8'($urandom);
            m2 = 8'($urandom);
            @(negedge clk);
            pin_in = 8'($urandom);
            wr(12'h400, d);
            wr({2'b00, m, 2'b00}, wd);
            model_out = exp_write(model_out, d, m, wd);
            tick(2);
            chk("R3 random pin_out", pin_out, model_out);
            chk("R3 random pin_oe", pin_oe, d);
            rd({2'b00, m2, 2'b00}, v);
            chk("R4 random masked read", v, exp_read(d, model_out, pin_in, m2));
        end

        // R4 sync latency of a data read
        wr(12'h400, 8'h00);
        @(negedge clk); pin_in = 8'h00; tick(3);
        @(negedge clk); pin_in = 8'hA5;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = 12'h3FC;
        #0.5 chk("R4 one edge not yet visible", bus_rdata, 8'h00);
        bus_sel = 1'b0;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_addr = 12'h3FC;
        #0.5 chk("R4 visible after two edges", bus_rdata, 8'hA5);
        bus_sel = 1'b0;

        // R5 level mode
        @(negedge clk); pin_in = 8'h00;
        wr(12'h40C, 8'h0F);
        wr(12'h404, 8'hFF);
        tick(3);
        chk_reg("R5 level raw", 12'h414, exp_level(8'h00, 8'h0F));
        for (int k = 0; k < 10; k++) begin
            logic [7:0] p;
            p = 8'($urandom);
            @(negedge clk); pin_in = p;
            tick(3);
            chk_reg("R5 random level", 12'h414, exp_level(p, 8'h0F));
        end
        @(negedge clk); pin_in = 8'hFF; tick(3);
        @(negedge clk); pin_in = 8'h00;
        @(posedge clk); @(posedge clk); #1;
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = 12'h414;
        #0.5 chk("R5 level follows after two edges", bus_rdata, exp_level(8'h00, 8'h0F));
        bus_sel = 1'b0;

        // R6 single edge
        wr(12'h404, 8'h00);
        wr(12'h408, 8'h00);
        wr(12'h41C, 8'hFF);
        chk_reg("R6 idle", 12'h414, 8'h00);
        @(negedge clk); pin_in = 8'hFF;
        @(posedge clk); @(posedge clk); #1;
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = 12'h414;
        #0.5 chk("R6 not latched after two edges", bus_rdata, 8'h00);
        bus_sel = 1'b0;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_addr = 12'h414;
        #0.5 chk("R6 rising latched after three edges", bus_rdata, 8'h0F);
        bus_sel = 1'b0;
        @(negedge clk); pin_in = 8'h00; tick(4);
        chk_reg("R6 falling latched", 12'h414, 8'hFF);
        wr(12'h41C, 8'hFF);
        chk_reg("R9 clear all", 12'h414, 8'h00);

        // R7 both edges, polarity ignored
        wr(12'h408, 8'hF0);
        wr(12'h40C, 8'hA0);
        @(negedge clk); pin_in = 8'hFF; tick(4);
        chk_reg("R7 rise on both-edge lines", 12'h414, 8'hF0);
        wr(12'h41C, 8'hFF);
        @(negedge clk); pin_in = 8'h00; tick(4);
        chk_reg("R7 fall on both-edge and falling lines", 12'h414, 8'hFF);

        // R8 masking and combined request
        wr(12'h410, 8'h3C);
        chk_reg("R8 masked", 12'h418, 8'h3C);
        chk("R8 irq high", {7'd0, irq}, 8'h01);
        wr(12'h410, 8'h00);
        chk_reg("R8 masked none", 12'h418, 8'h00);
        chk("R8 irq low", {7'd0, irq}, 8'h00);

        // R9 partial clear
        wr(12'h41C, 8'h05);
        chk_reg("R9 partial clear", 12'h414, 8'hFA);
        wr(12'h41C, 8'h00);
        chk_reg("R9 zero bits no effect", 12'h414, 8'hFA);

        // R10 writes to status registers
        wr(12'h414, 8'h00);
        wr(12'h418, 8'hFF);
        chk_reg("R10 status writes ignored", 12'h414, 8'hFA);

        // R9 edge and clear on the same clock edge
        wr(12'h408, 8'hFF);
        wr(12'h41C, 8'hFF);
        @(negedge clk); pin_in = 8'hFF; tick(4);
        chk_reg("R9 all latched", 12'h414, 8'hFF);
        @(negedge clk); pin_in = 8'h00;
        @(negedge clk);
        wr(12'h41C, 8'hFF);
        chk_reg("R9 edge wins over clear", 12'h414, 8'hFF);
        wr(12'h410, 8'h81);
        chk("R9 irq still raised", {7'd0, irq}, 8'h01);
        wr(12'h410, 8'h00);

        // R10 clear does not touch level status
        wr(12'h40C, 8'hFF);
        wr(12'h404, 8'hFF);
        @(negedge clk); pin_in = 8'hFF; tick(3);
        wr(12'h41C, 8'hFF);
        chk_reg("R10 level survives clear", 12'h414, 8'hFF);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule